// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. The host issues single-beat reads and writes over a request/ready handshake. The controller produces the RAM's strobes: an active-low select, an active-high select, an active-low output enable and an active-low write enable. It also drives the address and runs a split data path (drive value, drive enable, captured input) toward the pad that forms the shared tri-state bus. Read data goes back to the host with a one-cycle valid pulse.

Every timing minimum of the RAM is a parameter in nanoseconds. Each is converted to a whole number of clock cycles by rounding up against a clock-period parameter. Where several minimums bound the same phase, the largest count wins, so one netlist can serve slower or faster grades by changing parameters. After a read, the controller waits out the RAM's output float time before any other access. It keeps write data on the bus for one cycle after the write strobe rises. It also offers a low-power retention state that pulls the active-high select low, and on exit it waits one read-cycle time before the next access.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever the controller is idle, the active-low select, output enable and write enable are high, the active-high select is high, the bus drive enable is low, `rd_valid` is low and `ready` is high.
- R2: A request with `req_wr`=1 taken while `ready` is high holds the active-low select and write enable low, with the active-high select high, for exactly WR cycles. WR is the largest of the rounded-up write pulse, address-to-end, select-to-end and data-setup times. Throughout those cycles the bus is driven with the request's data and the address is the request's address.
- R3: After the write strobe rises, the drive enable stays high for exactly one more cycle with `ready` low, and `ready` is high on the cycle after that.
- R4: A request with `req_wr`=0 holds the active-low select and output enable low, with write enable high and the drive enable low, for exactly RD cycles. RD is the largest of the rounded-up read cycle, address access and output-enable access times. The drive enable is never high while output enable is low.
- R5: The bus byte is captured at the clock edge that ends the read strobe. `rd_data` carries it, and `rd_valid` is high for exactly that one following cycle.
- R6: After a read, all strobes stay inactive and `ready` stays low for exactly HZ cycles, the rounded-up output float time. A write presented as soon as possible after a read therefore first drives the bus HZ+1 cycles after output enable rises.
- R7: A request pulse seen while `ready` is low is dropped: it causes no strobe activity and no memory change.
- R8: With `ret_req` high while idle and no request pending, the next cycle has the active-high select low, all active-low strobes high, no drive and `ready` low. Requests during retention are dropped, so memory contents are untouched.
- R9: When `ret_req` falls during retention, the active-high select returns high at once and `ready` stays low for exactly WAKE cycles, the rounded-up read cycle time.
- R10: If a request and `ret_req` are both high in an idle cycle, the request is served first and retention follows once the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | DATA_W | Last captured read byte |
| rd_valid | output | 1 | One-cycle pulse with new read data |
| ret_req | input | 1 | Level request for low-power retention |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_out | output | DATA_W | Byte to drive onto the shared bus |
| mem_dq_oe | output | 1 | Drive enable for the bus pad |
| mem_dq_in | input | DATA_W | Byte seen on the shared bus |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
All pins are registered, so the strobes change on the first edge after an accepted request. A write stays in its strobe phase for WR cycles, then one hold cycle, and `ready` returns WR+1 edges after acceptance. Read data and `rd_valid` appear RD edges after acceptance, `ready` returns HZ edges later, and retention exit takes WAKE edges. The bench drives at falling edges and samples between edges. It counts the falling edges spent in each phase and compares these counts with WR, RD, HZ and WAKE, which it derives from the same nanosecond figures using its own round-up. It uses a 12 ns clock so that several figures round up rather than divide exactly. Its RAM model returns valid data only once the address access time has elapsed at the capturing edge, so a capture one cycle early returns a wrong byte.

// File: rtl/sram_async_pkg.sv
`timescale 1ns/1ps
package sram_async_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WHOLD,
        ST_READ,
        ST_TURN,
        ST_RETAIN,
        ST_WAKE
    } ctl_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each controller state.
    function automatic pin_ctl_t pins_for(input ctl_state_e st);
        pin_ctl_t p;
        p = '{ce1_n: 1'b1, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (st)
            ST_WRITE: begin
                p.ce1_n = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WHOLD: begin
                p.drive = 1'b1;
            end
            ST_READ: begin
                p.ce1_n = 1'b0;
                p.oe_n  = 1'b0;
            end
            ST_RETAIN: begin
                p.ce2 = 1'b0;
            end
            default: begin
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
`timescale 1ns/1ps
module sram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap_en;
        if (cap_en) begin
            cap_d.data = bus_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata  = cap_q.data;
    assign rvalid = cap_q.valid;

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
    import sram_async_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WPULSE_NS   = 40,
    parameter int T_ADDR_END_NS = 60,
    parameter int T_SEL_END_NS  = 60,
    parameter int T_DSETUP_NS   = 30,
    parameter int T_RCYCLE_NS   = 70,
    parameter int T_ADDR_ACC_NS = 70,
    parameter int T_OE_ACC_NS   = 35,
    parameter int T_FLOAT_NS    = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              ret_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    // Phase lengths in clock cycles, each the largest rounded-up bound.
    localparam int WR_CYC   = max2(max2(ns_to_cycles(T_WPULSE_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_ADDR_END_NS, CLK_PERIOD_NS)),
                                   max2(ns_to_cycles(T_SEL_END_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS)));
    localparam int RD_CYC   = max2(max2(ns_to_cycles(T_RCYCLE_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS)),
                                   ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int HZ_CYC   = ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int WAKE_CYC = ns_to_cycles(T_RCYCLE_NS, CLK_PERIOD_NS);
    localparam int LONGEST  = max2(max2(WR_CYC, RD_CYC), max2(HZ_CYC, WAKE_CYC));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    typedef struct packed {
        ctl_state_e        state;
        logic              ready;
        pin_ctl_t          pins;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctl_regs_t;

    ctl_regs_t        regs_d, regs_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cap_en;

    sram_cyc_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    sram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .bus_in(mem_dq_in),
        .rdata (rd_data),
        .rvalid(rd_valid)
    );

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                if (req && regs_q.ready) begin
                    regs_d.addr = req_addr;
                    tmr_load    = 1'b1;
                    if (req_wr) begin
                        regs_d.wdata = req_wdata;
                        regs_d.state = ST_WRITE;
                        tmr_val      = CNT_W'(WR_CYC - 1);
                    end else begin
                        regs_d.state = ST_READ;
                        tmr_val      = CNT_W'(RD_CYC - 1);
                    end
                end else if (ret_req) begin
                    regs_d.state = ST_RETAIN;
                end
            end
            ST_WRITE: begin
                if (tmr_zero) begin
                    regs_d.state = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                regs_d.state = ST_IDLE;
            end
            ST_READ: begin
                if (tmr_zero) begin
                    cap_en       = 1'b1;
                    regs_d.state = ST_TURN;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(HZ_CYC - 1);
                end
            end
            ST_TURN: begin
                if (tmr_zero) begin
                    regs_d.state = ST_IDLE;
                end
            end
            ST_RETAIN: begin
                if (!ret_req) begin
                    regs_d.state = ST_WAKE;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (tmr_zero) begin
                    regs_d.state = ST_IDLE;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
        regs_d.ready = (regs_d.state == ST_IDLE);
        regs_d.pins  = pins_for(regs_d.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.ready <= 1'b1;
            regs_q.pins  <= pins_for(ST_IDLE);
            regs_q.addr  <= '0;
            regs_q.wdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready      = regs_q.ready;
    assign mem_addr   = regs_q.addr;
    assign mem_dq_out = regs_q.wdata;
    assign mem_dq_oe  = regs_q.pins.drive;
    assign mem_ce1_n  = regs_q.pins.ce1_n;
    assign mem_ce2    = regs_q.pins.ce2;
    assign mem_oe_n   = regs_q.pins.oe_n;
    assign mem_we_n   = regs_q.pins.we_n;

endmodule

// File: rtl/sram_async_ctl_chk.sv
`timescale 1ns/1ps
module sram_async_ctl_chk #(
    parameter int HZ_CYC = 1,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);

    // Cycles since output enable was last low, saturating at HZ_CYC.
    int gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= HZ_CYC;
        end else if (!mem_oe_n) begin
            gap_q <= 0;
        end else if (gap_q < HZ_CYC) begin
            gap_q <= gap_q + 1;
        end
    end

    a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce1_n && mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce1_n && mem_ce2));

    a_r2_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    a_r3_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_q >= HZ_CYC));

    a_r8_retain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce2 |-> (mem_ce1_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ready));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .HZ_CYC(HZ_CYC),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out)
);

// File: tb/sram_async_ctl_test.sv
`timescale 1ns/1ps
module sram_async_ctl_test;

    localparam int CLK_NS = 12;
    localparam int HALF   = CLK_NS / 2;
    localparam int T_WP = 40, T_AW = 60, T_CW = 60, T_DW = 30;
    localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_HZ = 30;

    function automatic int cdiv(input int t);
        return (t + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int big(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WR_EXP   = big(big(cdiv(T_WP), cdiv(T_AW)), big(cdiv(T_CW), cdiv(T_DW)));
    localparam int RD_EXP   = big(big(cdiv(T_RC), cdiv(T_AA)), cdiv(T_OE));
    localparam int HZ_EXP   = cdiv(T_HZ);
    localparam int WAKE_EXP = cdiv(T_RC);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0, ret_req = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, mem_dq_oe;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [12:0] mem_addr;

    int n_checks = 0;
    int n_err = 0;

    always #(HALF) clk = ~clk;

    sram_async_ctl #(
        .ADDR_W(13), .DATA_W(8), .CLK_PERIOD_NS(CLK_NS),
        .T_WPULSE_NS(T_WP), .T_ADDR_END_NS(T_AW), .T_SEL_END_NS(T_CW),
        .T_DSETUP_NS(T_DW), .T_RCYCLE_NS(T_RC), .T_ADDR_ACC_NS(T_AA),
        .T_OE_ACC_NS(T_OE), .T_FLOAT_NS(T_HZ)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .ret_req(ret_req),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // RAM model: writes while selected with write enable low; read data
    // only once the address access time has elapsed at the next rising edge.
    logic [7:0] ram [int];
    bit         rd_was = 1'b0;
    longint     rd_start = 0;

    always @(posedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_we_n && mem_dq_oe) begin
            ram[int'(mem_addr)] = mem_dq_out;
        end
    end

    always @(negedge clk) begin
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            if (!rd_was) rd_start = $time - HALF;
            rd_was = 1'b1;
            if (($time + HALF - rd_start) >= T_AA && ram.exists(int'(mem_addr)))
                mem_dq_in = ram[int'(mem_addr)];
            else
                mem_dq_in = 8'hEE;
        end else begin
            rd_was = 1'b0;
            mem_dq_in = 8'hEE;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", ready, 1);
        chk("R1", "select low-active idle", mem_ce1_n, 1);
        chk("R1", "select high-active idle", mem_ce2, 1);
        chk("R1", "strobes idle", {mem_oe_n, mem_we_n}, 2'b11);
        chk("R1", "no drive", mem_dq_oe, 0);
        chk("R1", "no valid", rd_valid, 0);
    endtask

    task automatic t_write(input logic [12:0] a, input logic [7:0] d);
        int n = 0;
        int bad = 0;
        issue(1'b1, a, d);
        while (mem_we_n == 1'b0 && n < 64) begin
            if (!(mem_dq_oe && mem_dq_out == d && mem_addr == a &&
                  !mem_ce1_n && mem_ce2 && mem_oe_n)) bad++;
            n++;
            @(negedge clk);
        end
        chk("R2", "write strobe cycles", n, WR_EXP);
        chk("R2", "pins during write", bad, 0);
        chk("R3", "drive held after strobe", mem_dq_oe, 1);
        chk("R3", "ready low in hold", ready, 0);
        @(negedge clk);
        chk("R3", "ready back after write", ready, 1);
        chk("R3", "bus released", mem_dq_oe, 0);
    endtask

    task automatic t_read(input logic [12:0] a, input logic [7:0] exp);
        int n = 0;
        int bad = 0;
        int m = 0;
        int vc = 0;
        int bad2 = 0;
        issue(1'b0, a, 8'h00);
        while (!mem_oe_n && n < 64) begin
            if (!(!mem_ce1_n && mem_ce2 && mem_we_n && !mem_dq_oe &&
                  !rd_valid && mem_addr == a)) bad++;
            n++;
            @(negedge clk);
        end
        chk("R4", "read strobe cycles", n, RD_EXP);
        chk("R4", "pins during read", bad, 0);
        chk("R5", "valid after read", rd_valid, 1);
        chk("R5", "read data", rd_data, exp);
        while (!ready && m < 64) begin
            if (rd_valid) vc++;
            if (mem_dq_oe || !mem_ce1_n || !mem_oe_n) bad2++;
            m++;
            @(negedge clk);
        end
        chk("R6", "float interval cycles", m, HZ_EXP);
        chk("R5", "valid pulse width", vc, 1);
        chk("R6", "quiet during float", bad2, 0);
    endtask

    task automatic t_ignore;
        int lows = 0;
        issue(1'b0, 13'h0AAA, 8'h00);
        req = 1'b1; req_wr = 1'b1; req_addr = 13'h0AAA; req_wdata = 8'h00;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0;
        for (int i = 0; i < RD_EXP + HZ_EXP + 4; i++) begin
            if (!mem_we_n) lows++;
            @(negedge clk);
        end
        chk("R7", "busy request caused write", lows, 0);
        t_read(13'h0AAA, 8'h81);
    endtask

    task automatic t_turnaround;
        int n = 0;
        int w = 0;
        issue(1'b0, 13'h0123, 8'h00);
        req = 1'b1; req_wr = 1'b1; req_addr = 13'h0123; req_wdata = 8'h6D;
        while (!mem_oe_n && w < 64) begin w++; @(negedge clk); end
        while (!mem_dq_oe && n < 64) begin n++; @(negedge clk); end
        req = 1'b0; req_wr = 1'b0;
        chk("R6", "read-to-write drive gap", n, HZ_EXP + 1);
        while (!ready) @(negedge clk);
        t_read(13'h0123, 8'h6D);
    endtask

    task automatic t_retention;
        int acts = 0;
        int n = 0;
        int bad = 0;
        t_write(13'h0010, 8'h55);
        ret_req = 1'b1;
        @(negedge clk);
        chk("R8", "high-active select low", mem_ce2, 0);
        chk("R8", "low-active select high", mem_ce1_n, 1);
        chk("R8", "ready low in retention", ready, 0);
        req = 1'b1; req_wr = 1'b1; req_addr = 13'h0010; req_wdata = 8'hFF;
        @(negedge clk);
        req = 1'b0; req_wr = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (!mem_we_n || !mem_oe_n || mem_dq_oe) acts++;
            @(negedge clk);
        end
        chk("R8", "strobes in retention", acts, 0);
        ret_req = 1'b0;
        @(negedge clk);
        while (!ready && n < 64) begin
            if (!mem_ce2) bad++;
            n++;
            @(negedge clk);
        end
        chk("R9", "wake cycles", n, WAKE_EXP);
        chk("R9", "select high during wake", bad, 0);
        t_read(13'h0010, 8'h55);
    endtask

    task automatic t_priority;
        int n = 0;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_addr = 13'h1FFF; ret_req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R10", "read served first", mem_oe_n, 0);
        chk("R10", "not retained yet", mem_ce2, 1);
        while (!rd_valid && n < 64) begin n++; @(negedge clk); end
        chk("R10", "read data before retention", rd_data, 8'h3C);
        n = 0;
        while (mem_ce2 && n < 64) begin n++; @(negedge clk); end
        chk("R10", "retention after read", mem_ce2, 0);
        ret_req = 1'b0;
        n = 0;
        while (!ready && n < 64) begin n++; @(negedge clk); end
        chk("R9", "ready after wake", ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_write(13'h0000, 8'hA5);
        t_write(13'h1FFF, 8'h3C);
        t_write(13'h0AAA, 8'h81);
        t_read(13'h0000, 8'hA5);
        t_read(13'h1FFF, 8'h3C);
        t_read(13'h0AAA, 8'h81);
        t_ignore();
        t_turnaround();
        t_retention();
        t_priority();
        @(negedge clk);
        chk("R1", "idle at end", {ready, mem_ce1_n, mem_ce2, mem_dq_oe}, 4'b1110);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule